// File: doc/BRIEF.md
# Phase-Zero SPI Master

This block is a serial peripheral interface master that handles only the two phase-zero modes: clock polarity 0 (mode 0) and clock polarity 1 (mode 2). A host hands it a parallel word, a word length and a one-cycle start strobe. The block then frames that single word with its own active-low chip select, drives the serial clock and the outgoing data most-significant bit first, and collects the incoming data into a right-aligned parallel word.

Because phase is zero, the first outgoing bit appears on the data line at the same moment chip select goes active. This is half a serial-clock period before the first clock edge, so the slave can sample that bit on edge 1. Odd edges sample and even edges shift. After the last edge the block holds chip select for a lag and then releases it. It keeps the line idle for a gap before the next word can start, so chip select always returns high between words.

A 3-pin option holds chip select low for the whole time and leaves the clock and data waveforms unchanged. The serial clock rate is set by a parameter that gives the number of system clocks in each half serial period.

Top module: `spi_p0_master`

## Requirements
- R1: After reset, and while idle with the 3-pin option off, `cs_n_o` is 1, `busy_o` is 0, `rx_valid_o` is 0 and `sclk_o` sits at the level of `cpol_i`.
- R2: A `start_i` pulse seen while `busy_o` is 0 is accepted. In the next cycle `busy_o` is 1, `cs_n_o` is 0 and `mosi_o` carries bit L-1 of `tx_data_i`, where L is the effective word length.
- R3: The first serial-clock edge comes HALF_DIV system cycles after chip select is asserted. Every later edge follows the one before it by HALF_DIV cycles, and each word has exactly 2·L edges (L pulses).
- R4: Bits leave MSB first, covering bits L-1 down to 0 of `tx_data_i`. `mosi_o` changes only on even edges (clock returning to idle), never on odd edges.
- R5: `miso_i` is sampled on odd edges, MSB first. In the cycle after the last odd edge, `rx_data_o` holds the received word right-aligned with zero upper bits, and `rx_valid_o` is 1 for exactly one cycle per word.
- R6: `cpol_i` selects the idle clock level (0 for polarity 0, 1 for polarity 1). It is taken while idle and held fixed for the whole word; the edge numbering is the same for both levels.
- R7: The effective length L is `word_len_i` clamped to the range 4..DATA_W. A request below 4 gives 4, and a request above DATA_W gives DATA_W.
- R8: Chip select is released LAG_HALVES·HALF_DIV cycles after the last edge. `busy_o` falls IDLE_HALVES·HALF_DIV cycles after the release, so chip select stays high for at least that long between words. The clock is at its idle level whenever chip select is high.
- R9: A `start_i` pulse while `busy_o` is 1 has no effect: no extra word, no extra `rx_valid_o`, and the word in flight is unchanged.
- R10: With `three_pin_i` set, `cs_n_o` stays 0 for the whole word. `busy_o` then falls (LAG_HALVES+IDLE_HALVES)·HALF_DIV cycles after the last edge, and the clock and data timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one word |
| tx_data_i | input | DATA_W | Word to send, right-aligned |
| word_len_i | input | $clog2(DATA_W+1) | Requested word length in bits |
| cpol_i | input | 1 | Clock polarity (idle level) |
| three_pin_i | input | 1 | 1 holds chip select low permanently |
| busy_o | output | 1 | High from the accepted start to the end of the idle gap |
| rx_data_o | output | DATA_W | Received word, right-aligned |
| rx_valid_o | output | 1 | One-cycle pulse marking a new received word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
The hardest case to reach is two words meeting at their boundary. A start must land in the very first cycle after `busy_o` falls, which exercises the minimum chip-select-high gap; a start must also arrive in the middle of a word, where it has to be ignored. The driver task reaches the first case by polling `busy_o` at every falling clock edge and issuing the next start at once. It reaches the second by firing a conflicting start partway through a transfer. A slave model driven only from the pins measures every edge spacing, the lag and the gap. Words at the clamp limits and in 3-pin mode run through the same scoreboard.

// File: rtl/spi_p0_pkg.sv
package spi_p0_pkg;

    localparam int unsigned SPI_MIN_LEN = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_LAG,
        ST_GAP
    } spi_st_e;

    // Per-cycle commands from the sequencer to the shift datapath
    typedef struct packed {
        logic load;
        logic sample;
        logic shift;
        logic last;
    } shf_ctl_t;

    function automatic int unsigned fit_len(input int unsigned req, input int unsigned maxw);
        if (req < SPI_MIN_LEN) return SPI_MIN_LEN;
        if (req > maxw) return maxw;
        return req;
    endfunction

endpackage

// File: rtl/spi_p0_tick.sv
module spi_p0_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_every
            logic unused_rst;
            assign unused_rst = rst;
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            logic [CW-1:0] cnt;
            assign tick = run && (cnt == CW'(HALF_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || !run || tick) cnt <= '0;
                else                     cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_p0_shifter.sv
module spi_p0_shifter
    import spi_p0_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  shf_ctl_t          ctl,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid
);
    logic [DATA_W-1:0] txsh;
    logic [DATA_W-1:0] rxsh;
    logic [LEN_W-1:0]  sh_amt;

    assign sh_amt = LEN_W'(DATA_W) - len;
    assign mosi   = txsh[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            txsh     <= '0;
            rxsh     <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= ctl.sample && ctl.last;
            if (ctl.load) begin
                txsh <= tx_word << sh_amt;
                rxsh <= '0;
            end else begin
                if (ctl.shift)  txsh <= {txsh[DATA_W-2:0], 1'b0};
                if (ctl.sample) rxsh <= {rxsh[DATA_W-2:0], miso};
            end
            if (ctl.sample && ctl.last) rx_word <= {rxsh[DATA_W-2:0], miso};
        end
    end
endmodule

// File: rtl/spi_p0_master.sv
module spi_p0_master
    import spi_p0_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int HALF_DIV    = 2,
    parameter int LAG_HALVES  = 1,
    parameter int IDLE_HALVES = 2,
    localparam int LEN_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic [LEN_W-1:0]  word_len_i,
    input  logic              cpol_i,
    input  logic              three_pin_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              cs_n_o
);
    localparam int EDGE_W = LEN_W + 1;
    localparam int HV_MAX = (LAG_HALVES > IDLE_HALVES) ? LAG_HALVES : IDLE_HALVES;
    localparam int HV_W   = $clog2(HV_MAX + 1);

    spi_st_e          state;
    logic             tick;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_fit;
    logic [EDGE_W-1:0] ecnt;
    logic [EDGE_W-1:0] edge_n;
    logic [EDGE_W-1:0] last_edge;
    logic [HV_W-1:0]  hv;
    logic             sclk_act;
    logic             cs_act;
    logic             cpol_q;
    logic             three_q;
    shf_ctl_t         ctl;

    assign len_fit   = LEN_W'(fit_len(32'(word_len_i), DATA_W));
    assign edge_n    = (state == ST_LEAD) ? EDGE_W'(1) : ecnt + 1'b1;
    assign last_edge = {len_q, 1'b0};

    assign busy_o = (state != ST_IDLE);
    assign sclk_o = sclk_act ^ cpol_q;
    assign cs_n_o = three_q ? 1'b0 : ~cs_act;

    spi_p0_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_o),
        .tick (tick)
    );

    always_comb begin
        ctl = '0;
        ctl.load = (state == ST_IDLE) && start_i;
        if (tick && (state == ST_LEAD || state == ST_SHIFT)) begin
            ctl.sample = edge_n[0];
            ctl.shift  = ~edge_n[0];
        end
        ctl.last = (edge_n == last_edge - 1'b1);
    end

    spi_p0_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shf (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .tx_word  (tx_data_i),
        .len      (ctl.load ? len_fit : len_q),
        .miso     (miso_i),
        .mosi     (mosi_o),
        .rx_word  (rx_data_o),
        .rx_valid (rx_valid_o)
    );

    // Polarity and pin mode follow the inputs only between words
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) begin
            cpol_q  <= cpol_i;
            three_q <= three_pin_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            len_q    <= '0;
            ecnt     <= '0;
            hv       <= '0;
            sclk_act <= 1'b0;
            cs_act   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    state  <= ST_LEAD;
                    cs_act <= 1'b1;
                    len_q  <= len_fit;
                    ecnt   <= '0;
                end
                ST_LEAD: if (tick) begin
                    state    <= ST_SHIFT;
                    sclk_act <= 1'b1;
                    ecnt     <= edge_n;
                end
                ST_SHIFT: if (tick) begin
                    ecnt     <= edge_n;
                    sclk_act <= edge_n[0];
                    if (edge_n == last_edge) begin
                        state <= ST_LAG;
                        hv    <= '0;
                    end
                end
                ST_LAG: if (tick) begin
                    if (hv == HV_W'(LAG_HALVES - 1)) begin
                        state  <= ST_GAP;
                        cs_act <= 1'b0;
                        hv     <= '0;
                    end else begin
                        hv <= hv + 1'b1;
                    end
                end
                ST_GAP: if (tick) begin
                    if (hv == HV_W'(IDLE_HALVES - 1)) state <= ST_IDLE;
                    else                              hv    <= hv + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_p0_master_chk.sv
module spi_p0_master_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o,
    input logic rx_valid_o,
    input logic cpol_q,
    input logic three_q
);
    p_cs_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !three_q) |-> cs_n_o);

    p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !cs_n_o));

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (sclk_o != $past(sclk_o)) && (sclk_o != cpol_q)) |-> $stable(mosi_o));

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    p_valid_in_word_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> busy_o);

    p_clk_idle_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> (sclk_o == cpol_q));

    p_word_in_flight_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !cs_n_o) |=> (busy_o || cs_n_o || three_q));
endmodule

bind spi_p0_master spi_p0_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .rx_valid_o (rx_valid_o),
    .cpol_q     (cpol_q),
    .three_q    (three_q)
);

// File: tb/spi_p0_master_tb.sv
module spi_p0_master_tb;
    localparam int W    = 32;
    localparam int LW   = 6;
    localparam int H    = 3;
    localparam int LAG  = 2;
    localparam int IDLE = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [W-1:0] tx_data_i = '0;
    logic [LW-1:0] word_len_i = '0;
    logic cpol_i = 1'b0;
    logic three_pin_i = 1'b0;
    logic busy_o, rx_valid_o, sclk_o, mosi_o, cs_n_o;
    logic miso_i = 1'b0;
    logic [W-1:0] rx_data_o;

    always #2.5 clk = ~clk;

    spi_p0_master #(.DATA_W(W), .HALF_DIV(H), .LAG_HALVES(LAG), .IDLE_HALVES(IDLE)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .tx_data_i(tx_data_i),
        .word_len_i(word_len_i), .cpol_i(cpol_i), .three_pin_i(three_pin_i),
        .busy_o(busy_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
    );

    typedef struct {
        logic [31:0] tx;
        logic [31:0] sl;
        int          len;
        bit          cpol;
        bit          three;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0, n_fail = 0, n_valid = 0, n_words = 0, cyc = 0;
    bit finished = 0;
    bit three_b = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int clampf(input int req);
        if (req < 4) return 4;
        if (req > W) return W;
        return req;
    endfunction

    function automatic logic [31:0] maskf(input int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Driver: pushes the expected item, then issues the start strobe
    task automatic send(input logic [31:0] tx, input logic [31:0] sl, input int req,
                        input bit cp, input bit tp, input string tag);
        item_t it;
        while (busy_o) @(negedge clk);
        cpol_i = cp; three_pin_i = tp; three_b = tp;
        it.tx = tx; it.sl = sl; it.len = clampf(req); it.cpol = cp; it.three = tp; it.tag = tag;
        exp_q.push_back(it);
        n_words++;
        tx_data_i = tx; word_len_i = LW'(req); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !cs_n_o, "R2", {30'd0, busy_o, cs_n_o}, 32'h2);
    endtask

    // Slave model and timing monitor, driven from the pins only
    item_t cur;
    bit in_frame = 0, prev_sclk = 0, spacing_bad = 0, cs_bad = 0, have_rise = 0, wait_busy = 0;
    int edges = 0, frame_cyc = 0, last_edge_cyc = 0, cs_rise_cyc = 0, vstart = 0;
    logic [31:0] mrx = '0, sl_sh = '0;

    always @(negedge clk) begin
        if (rst) begin
            in_frame = 0; prev_sclk = sclk_o;
        end else begin
            if (!in_frame && busy_o && (three_b || !cs_n_o)) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", 32'd1, 32'd0);
                end else begin
                    cur = exp_q[0]; in_frame = 1; frame_cyc = cyc; last_edge_cyc = cyc;
                    edges = 0; spacing_bad = 0; cs_bad = 0; mrx = '0; vstart = n_valid;
                    sl_sh = cur.sl << (32 - cur.len); miso_i = sl_sh[31];
                    chk(mosi_o == cur.tx[cur.len-1], "R2", {31'd0, mosi_o}, {31'd0, cur.tx[cur.len-1]});
                    chk(sclk_o == cur.cpol, "R6", {31'd0, sclk_o}, {31'd0, cur.cpol});
                    if (!cur.three && have_rise)
                        chk(cyc - cs_rise_cyc >= IDLE*H, "R8", cyc - cs_rise_cyc, IDLE*H);
                end
            end else if (in_frame) begin
                if (cur.three && cs_n_o) cs_bad = 1;
                if (sclk_o != prev_sclk) begin
                    edges++;
                    if (edges == 1) chk(cyc - frame_cyc == H, "R3", cyc - frame_cyc, H);
                    else if (cyc - last_edge_cyc != H) spacing_bad = 1;
                    last_edge_cyc = cyc;
                    if (sclk_o != cur.cpol) mrx = {mrx[30:0], mosi_o};
                    else begin sl_sh = sl_sh << 1; miso_i = sl_sh[31]; end
                end
                if (cur.three ? !busy_o : cs_n_o) begin
                    in_frame = 0;
                    chk(edges == 2*cur.len, cur.tag, edges, 2*cur.len);
                    chk(!spacing_bad, "R3", {31'd0, spacing_bad}, 32'd0);
                    chk(mrx == (cur.tx & maskf(cur.len)), "R4", mrx, cur.tx & maskf(cur.len));
                    chk(n_valid - vstart == 1, "R5", n_valid - vstart, 1);
                    if (cur.three) begin
                        chk(cyc - last_edge_cyc == (LAG+IDLE)*H, "R10", cyc - last_edge_cyc, (LAG+IDLE)*H);
                        chk(!cs_bad, "R10", {31'd0, cs_bad}, 32'd0);
                        have_rise = 0;
                    end else begin
                        chk(cyc - last_edge_cyc == LAG*H, "R8", cyc - last_edge_cyc, LAG*H);
                        cs_rise_cyc = cyc; have_rise = 1; wait_busy = 1;
                    end
                    void'(exp_q.pop_front());
                end
            end
            if (wait_busy && !busy_o) begin
                chk(cyc - cs_rise_cyc == IDLE*H, "R8", cyc - cs_rise_cyc, IDLE*H);
                wait_busy = 0;
            end
            prev_sclk = sclk_o;
        end
    end

    // Result monitor: compares each received word against the queue head
    always @(negedge clk) begin
        if (!rst && rx_valid_o) begin
            n_valid++;
            if (exp_q.size() == 0) chk(0, "R5", rx_data_o, 32'd0);
            else begin
                chk(rx_data_o == (exp_q[0].sl & maskf(exp_q[0].len)), "R5",
                    rx_data_o, exp_q[0].sl & maskf(exp_q[0].len));
                chk(sclk_o != exp_q[0].cpol, "R5", {31'd0, sclk_o}, {31'd0, ~exp_q[0].cpol});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected idle");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && cs_n_o && !rx_valid_o && !sclk_o, "R1",
            {28'd0, busy_o, cs_n_o, rx_valid_o, sclk_o}, 32'h4);
        // R6: idle level follows polarity
        cpol_i = 1'b1; repeat (2) @(negedge clk);
        chk(sclk_o == 1'b1, "R6", {31'd0, sclk_o}, 32'd1);
        cpol_i = 1'b0; repeat (2) @(negedge clk);
        chk(sclk_o == 1'b0, "R6", {31'd0, sclk_o}, 32'd0);

        send(32'hA5, 32'h3C, 8, 0, 0, "R3");
        send(32'h96, 32'h5A, 8, 1, 0, "R6");
        send(32'hB, 32'h6, 4, 0, 0, "R3");
        send(32'hDEADBEEF, 32'h13579BDF, 32, 1, 0, "R3");
        send(32'h1ABC, 32'h0F0F, 13, 0, 0, "R3");
        // R7: clamping of out-of-range lengths
        send(32'hFFFF_FFF9, 32'hC, 2, 0, 0, "R7");
        send(32'h8421_7BDE, 32'hC3A5_0F96, 50, 1, 0, "R7");

        // R9: start while busy is ignored
        send(32'h5E, 32'hA1, 8, 0, 0, "R3");
        repeat (12) @(negedge clk);
        tx_data_i = 32'hFF; word_len_i = LW'(16); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        begin
            bit stayed = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (busy_o || !cs_n_o) stayed = 0;
            end
            chk(stayed, "R9", {31'd0, stayed}, 32'd1);
            chk(n_valid == n_words, "R9", n_valid, n_words);
        end

        // R10: 3-pin words
        send(32'h3C, 32'hE7, 8, 1, 1, "R10");
        send(32'hBEEF, 32'h1234, 16, 0, 1, "R10");

        // R8: back-to-back words at minimum gap
        send(32'h71, 32'h8E, 8, 0, 0, "R8");
        send(32'h0D, 32'hF2, 8, 1, 0, "R8");

        while (busy_o || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(n_valid == n_words, "R5", n_valid, n_words);
        summary();
    end
endmodule